// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block owns the operating mode of a CAN controller. It keeps the controller in one of four modes: off, frozen (the only mode in which configuration may change), bus-synchronizing, and running. Software steers it through a small mode register holding four bits: disable, halt, freeze-enable and clock-source select. The block reports three read-only flags: freeze-acknowledge, not-ready and engine-enable. The protocol engine, bit timing and message storage sit outside. They are stood in for by a bit-rate tick, the receive line and the engine's own transmit bit.

Releasing the disable bit never starts traffic directly. The block first parks in the frozen mode with halt and freeze-enable forced on and both status flags raised. Clearing halt starts a hunt for an idle bus: the receive line is sampled once per bit tick until enough consecutive recessive bits have been seen. Only then does the controller run. While the engine is stopped, the transmit pin is held recessive. A configuration word is latched only while the controller is frozen or synchronizing.

Top module: `can_mode_seq`

## Requirements
- R1: During and after reset the controller is in mode code 0 (off). Disable, halt and freeze-enable read 1. Clock-source reads 0 and the configuration word reads 0. Freeze-acknowledge reads 0, not-ready reads 1, engine-enable reads 0 and the transmit pin reads 1.
- R2: A mode-register write loads disable from bit 0, halt from bit 1, freeze-enable from bit 2 and clock-source from bit 3. When disable reads 0 in mode 0, the next clock edge moves the controller to mode code 1 (frozen), never to any other mode. Every entry into mode 1 forces halt and freeze-enable to 1, overriding a write in the same cycle, and raises freeze-acknowledge and not-ready.
- R3: The clock-source bit takes the value written only when the controller is in mode 0 on the write cycle. A write in any other mode leaves the bit unchanged.
- R4: In every mode except mode 3, engine-enable is 0 and the transmit pin is 1.
- R5: A configuration write updates the configuration word only while freeze-acknowledge is 1, which holds in modes 1 and 2. In any other mode the write is dropped.
- R6: With halt at 0 in mode 1, the next edge enters mode code 2 (synchronizing). With halt at 1 in mode 2, the next edge returns to mode 1.
- R7: In mode 2, each cycle with the bit tick high samples the receive line. A 1 counts as recessive and a 0 clears the count, while cycles without a tick leave the count alone. The edge carrying the 11th consecutive recessive sample enters mode code 3 (running). Mode 3 is reached only from mode 2.
- R8: On the edge that enters mode 3, freeze-acknowledge and not-ready fall and engine-enable rises. In mode 3 the transmit pin follows the engine's transmit bit.
- R9: In mode 3 with halt and freeze-enable both 1, the controller returns to mode 1 on the first edge whose cycle carries a bit tick, raising freeze-acknowledge again. With freeze-enable 0, halt has no effect and the controller stays in mode 3.
- R10: With disable at 1 in modes 1, 2 or 3, the next edge enters mode 0. Mode 0 holds not-ready at 1, freeze-acknowledge at 0 and the transmit pin at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeWr | input | 1 | Mode-register write strobe |
| modeWdata | input | 4 | {clock-source, freeze-enable, halt, disable} |
| cfgWr | input | 1 | Configuration write strobe |
| cfgWdata | input | CFG_W | Configuration write data |
| bitTick | input | 1 | One pulse per nominal bit time |
| rxIn | input | 1 | Receive line, 1 = recessive |
| txEngine | input | 1 | Transmit bit from the protocol engine |
| txOut | output | 1 | Transmit pin |
| modeOut | output | 2 | Mode code: 0 off, 1 frozen, 2 synchronizing, 3 running |
| mdisOut | output | 1 | Disable bit |
| haltOut | output | 1 | Halt bit |
| frzEnOut | output | 1 | Freeze-enable bit |
| clkSrcOut | output | 1 | Clock-source select bit |
| frzAckOut | output | 1 | Freeze-acknowledge flag |
| notRdyOut | output | 1 | Not-ready flag |
| engineEn | output | 1 | Protocol engine run enable |
| cfgOut | output | CFG_W | Configuration word |

## Verification
The hardest situation to reach from the ports is a synchronization run that almost completes. For example, ten recessive ticks followed by a dominant one, or dominant levels between ticks that must not disturb the count. Random traffic rarely produces eleven clean ticks in a row either. Directed sequences therefore build these exact tick patterns while the controller is synchronizing, and they also drive halt with freeze-enable cleared while running. The seeded random phase then biases the receive line heavily toward recessive and keeps disable writes rare, so that every mode and transition recurs many times. A bench reference model checks all of it cycle by cycle.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_FROZEN = 2'd1,
    MODE_SYNC   = 2'd2,
    MODE_RUN    = 2'd3
  } canMode_e;

  // strobes from the sequencer to the register datapath
  typedef struct packed {
    logic ldMode;
    logic ldClkSrc;
    logic ldCfg;
    logic forceFreeze;
    logic cntStep;
    logic cntClr;
    logic ackNext;
    logic notRdyNext;
    logic runNext;
  } ctrlStb_t;

endpackage

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     modeWr,
  input  logic     cfgWr,
  input  logic     bitTick,
  input  logic     mdisQ,
  input  logic     haltQ,
  input  logic     frzEnQ,
  input  logic     syncHit,
  output canMode_e modeQ,
  output ctrlStb_t stb
);

  canMode_e modeNext;
  logic     syncDone;

  assign syncDone = (modeQ == MODE_SYNC) && syncHit;

  always_comb begin
    modeNext = modeQ;
    if (mdisQ && modeQ != MODE_OFF) begin
      modeNext = MODE_OFF;
    end else begin
      unique case (modeQ)
        MODE_OFF:    if (!mdisQ) modeNext = MODE_FROZEN;
        MODE_FROZEN: if (!haltQ) modeNext = MODE_SYNC;
        MODE_SYNC: begin
          if (haltQ)         modeNext = MODE_FROZEN;
          else if (syncDone) modeNext = MODE_RUN;
        end
        MODE_RUN:    if (haltQ && frzEnQ && bitTick) modeNext = MODE_FROZEN;
        default:     modeNext = MODE_OFF;
      endcase
    end
  end

  always_comb begin
    stb.ldMode      = modeWr;
    stb.ldClkSrc    = modeWr && (modeQ == MODE_OFF);
    stb.ldCfg       = cfgWr && (modeQ == MODE_FROZEN || modeQ == MODE_SYNC);
    stb.forceFreeze = (modeNext == MODE_FROZEN) && (modeQ != MODE_FROZEN);
    stb.cntStep     = (modeQ == MODE_SYNC) && bitTick;
    stb.cntClr      = (modeQ != MODE_SYNC) || syncDone;
    stb.ackNext     = (modeNext == MODE_FROZEN) || (modeNext == MODE_SYNC);
    stb.notRdyNext  = (modeNext != MODE_RUN);
    stb.runNext     = (modeNext == MODE_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_OFF;
    else       modeQ <= modeNext;
  end

endmodule

// File: rtl/can_mode_dp.sv
module can_mode_dp
  import can_mode_pkg::*;
#(
  parameter int CFG_W     = 16,
  parameter int SYNC_BITS = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic [3:0]       modeWdata,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             bitTick,
  input  logic             rxIn,
  input  logic             txEngine,
  output logic             mdisQ,
  output logic             haltQ,
  output logic             frzEnQ,
  output logic             clkSrcQ,
  output logic             frzAckQ,
  output logic             notRdyQ,
  output logic             runQ,
  output logic [CFG_W-1:0] cfgQ,
  output logic             syncHit,
  output logic             txOut
);

  localparam int CNT_W = $clog2(SYNC_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_BITS - 1);

  logic [CNT_W-1:0] recCnt;

  assign syncHit = bitTick && rxIn && (recCnt == CNT_LAST);
  assign txOut   = runQ ? txEngine : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mdisQ   <= 1'b1;
      haltQ   <= 1'b1;
      frzEnQ  <= 1'b1;
      clkSrcQ <= 1'b0;
    end else begin
      if (stb.ldMode) mdisQ <= modeWdata[0];
      if (stb.forceFreeze) begin
        haltQ  <= 1'b1;
        frzEnQ <= 1'b1;
      end else if (stb.ldMode) begin
        haltQ  <= modeWdata[1];
        frzEnQ <= modeWdata[2];
      end
      if (stb.ldClkSrc) clkSrcQ <= modeWdata[3];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frzAckQ <= 1'b0;
      notRdyQ <= 1'b1;
      runQ    <= 1'b0;
      cfgQ    <= '0;
    end else begin
      frzAckQ <= stb.ackNext;
      notRdyQ <= stb.notRdyNext;
      runQ    <= stb.runNext;
      if (stb.ldCfg) cfgQ <= cfgWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            recCnt <= '0;
    else if (stb.cntClr)  recCnt <= '0;
    else if (stb.cntStep) recCnt <= rxIn ? recCnt + 1'b1 : '0;
  end

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int CFG_W     = 16,
  parameter int SYNC_BITS = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWr,
  input  logic [3:0]       modeWdata,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             bitTick,
  input  logic             rxIn,
  input  logic             txEngine,
  output logic             txOut,
  output logic [1:0]       modeOut,
  output logic             mdisOut,
  output logic             haltOut,
  output logic             frzEnOut,
  output logic             clkSrcOut,
  output logic             frzAckOut,
  output logic             notRdyOut,
  output logic             engineEn,
  output logic [CFG_W-1:0] cfgOut
);

  canMode_e modeQ;
  ctrlStb_t stb;
  logic     syncHit;

  can_mode_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .cfgWr(cfgWr), .bitTick(bitTick),
    .mdisQ(mdisOut), .haltQ(haltOut), .frzEnQ(frzEnOut), .syncHit(syncHit),
    .modeQ(modeQ), .stb(stb)
  );

  can_mode_dp #(.CFG_W(CFG_W), .SYNC_BITS(SYNC_BITS)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .modeWdata(modeWdata), .cfgWdata(cfgWdata),
    .bitTick(bitTick), .rxIn(rxIn), .txEngine(txEngine),
    .mdisQ(mdisOut), .haltQ(haltOut), .frzEnQ(frzEnOut), .clkSrcQ(clkSrcOut),
    .frzAckQ(frzAckOut), .notRdyQ(notRdyOut), .runQ(engineEn), .cfgQ(cfgOut),
    .syncHit(syncHit), .txOut(txOut)
  );

  assign modeOut = modeQ;

endmodule

// File: rtl/can_mode_chk.sv
module can_mode_chk #(
  parameter int CFG_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             txOut,
  input logic [1:0]       modeOut,
  input logic             mdisOut,
  input logic             haltOut,
  input logic             frzEnOut,
  input logic             clkSrcOut,
  input logic             frzAckOut,
  input logic             notRdyOut,
  input logic             engineEn,
  input logic [CFG_W-1:0] cfgOut
);

  AST_OFF_LEADS_TO_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    modeOut == 2'd0 |=> (modeOut == 2'd0 || modeOut == 2'd1)); // R2

  AST_FREEZE_ENTRY_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd1 && $past(modeOut) != 2'd1) |-> (haltOut && frzEnOut && frzAckOut && notRdyOut)); // R2

  AST_CLKSRC_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    modeOut != 2'd0 |=> $stable(clkSrcOut)); // R3

  AST_TX_RECESSIVE_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    modeOut != 2'd3 |-> (txOut && !engineEn)); // R4

  AST_CFG_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !frzAckOut |=> $stable(cfgOut)); // R5

  AST_RUN_ONLY_FROM_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd0 || modeOut == 2'd1) |=> modeOut != 2'd3); // R7

  AST_RUN_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    modeOut == 2'd3 |-> (!frzAckOut && !notRdyOut && engineEn)); // R8

  AST_HALT_NEEDS_FREEZE_EN: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd3 && !frzEnOut && !mdisOut) |=> modeOut == 2'd3); // R9

  AST_OFF_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    modeOut == 2'd0 |-> (notRdyOut && !frzAckOut && txOut)); // R10

endmodule

bind can_mode_seq can_mode_chk #(.CFG_W(CFG_W)) i_chk (
  .clk(clk), .rstN(rstN), .txOut(txOut), .modeOut(modeOut), .mdisOut(mdisOut),
  .haltOut(haltOut), .frzEnOut(frzEnOut), .clkSrcOut(clkSrcOut),
  .frzAckOut(frzAckOut), .notRdyOut(notRdyOut), .engineEn(engineEn), .cfgOut(cfgOut)
);

// File: tb/test_can_mode_seq.sv
module test_can_mode_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CFG_W      = 16;
  localparam int SYNC_BITS  = 11;
  localparam int WATCHDOG   = 150000;
  localparam int RAND_CYC   = 4000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             modeWr = 1'b0;
  logic [3:0]       modeWdata = '0;
  logic             cfgWr = 1'b0;
  logic [CFG_W-1:0] cfgWdata = '0;
  logic             bitTick = 1'b0;
  logic             rxIn = 1'b1;
  logic             txEngine = 1'b1;
  logic             txOut, mdisOut, haltOut, frzEnOut, clkSrcOut, frzAckOut, notRdyOut, engineEn;
  logic [1:0]       modeOut;
  logic [CFG_W-1:0] cfgOut;

  int checks = 0;
  int errors = 0;

  // reference model state
  int               mMode;
  logic             mMdis, mHalt, mFrzEn, mClk, mAck, mNotRdy, mRun;
  logic [CFG_W-1:0] mCfg;
  int               mCnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_mode_seq #(.CFG_W(CFG_W), .SYNC_BITS(SYNC_BITS)) i_can_mode_seq (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .modeWdata(modeWdata), .cfgWr(cfgWr),
    .cfgWdata(cfgWdata), .bitTick(bitTick), .rxIn(rxIn), .txEngine(txEngine),
    .txOut(txOut), .modeOut(modeOut), .mdisOut(mdisOut), .haltOut(haltOut),
    .frzEnOut(frzEnOut), .clkSrcOut(clkSrcOut), .frzAckOut(frzAckOut),
    .notRdyOut(notRdyOut), .engineEn(engineEn), .cfgOut(cfgOut)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mMode = 0; mMdis = 1; mHalt = 1; mFrzEn = 1; mClk = 0; mCfg = '0;
    mAck = 0; mNotRdy = 1; mRun = 0; mCnt = 0;
  endtask

  function automatic int nextMode(input int m);
    if (mMdis && m != 0) return 0;
    case (m)
      0: return mMdis ? 0 : 1;
      1: return mHalt ? 1 : 2;
      2: begin
        if (mHalt) return 1;
        if (bitTick && rxIn && mCnt == SYNC_BITS - 1) return 3;
        return 2;
      end
      default: return (mHalt && mFrzEn && bitTick) ? 1 : 3;
    endcase
  endfunction

  task automatic modelEdge();
    int nm;
    logic nMdis, nHalt, nFrzEn, nClk;
    logic [CFG_W-1:0] nCfg;
    int nCnt;
    if (!rstN) begin
      modelReset();
      return;
    end
    nm = nextMode(mMode);
    nMdis = mMdis; nHalt = mHalt; nFrzEn = mFrzEn; nClk = mClk; nCfg = mCfg;
    if (modeWr) begin
      nMdis = modeWdata[0]; nHalt = modeWdata[1]; nFrzEn = modeWdata[2];
      if (mMode == 0) nClk = modeWdata[3];
    end
    if (nm == 1 && mMode != 1) begin nHalt = 1; nFrzEn = 1; end
    if (cfgWr && mAck) nCfg = cfgWdata;
    nCnt = mCnt;
    if (mMode != 2 || nm == 3) nCnt = 0;
    else if (bitTick) nCnt = rxIn ? mCnt + 1 : 0;
    mMode = nm; mMdis = nMdis; mHalt = nHalt; mFrzEn = nFrzEn; mClk = nClk; mCfg = nCfg; mCnt = nCnt;
    mAck = (nm == 1 || nm == 2); mNotRdy = (nm != 3); mRun = (nm == 3);
  endtask

  task automatic compareAll();
    chk("R7", "mode", 32'(modeOut), 32'(mMode));
    chk("R10", "disable", 32'(mdisOut), 32'(mMdis));
    chk("R2", "halt", 32'(haltOut), 32'(mHalt));
    chk("R2", "freezeEn", 32'(frzEnOut), 32'(mFrzEn));
    chk("R3", "clkSrc", 32'(clkSrcOut), 32'(mClk));
    chk("R8", "freezeAck", 32'(frzAckOut), 32'(mAck));
    chk("R8", "notReady", 32'(notRdyOut), 32'(mNotRdy));
    chk("R4", "engineEn", 32'(engineEn), 32'(mRun));
    chk("R4", "tx", 32'(txOut), 32'(mRun ? txEngine : 1'b1));
    chk("R5", "cfg", 32'(cfgOut), 32'(mCfg));
  endtask

  task automatic cyc();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    modeWr = 0; cfgWr = 0; bitTick = 0;
  endtask

  task automatic wrMode(input logic [3:0] d);
    idle(); modeWr = 1; modeWdata = d; cyc(); idle();
  endtask

  task automatic ticks(input int n, input logic rx);
    for (int i = 0; i < n; i++) begin
      idle(); bitTick = 1; rxIn = rx; cyc();
    end
    idle();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    modelReset();
    repeat (3) cyc();
    // R1 reset values
    chk("R1", "reset mode", 32'(modeOut), 0);
    chk("R1", "reset notReady", 32'(notRdyOut), 1);
    chk("R1", "reset tx", 32'(txOut), 1);
    @(negedge clk); rstN = 1;
    cyc();

    // R3 clock source accepted while off
    wrMode(4'b1001);
    chk("R3", "clkSrc written while off", 32'(clkSrcOut), 1);
    // R2 release disable, halt/freeze-en forced
    wrMode(4'b1000);
    chk("R2", "still off on write edge", 32'(modeOut), 0);
    cyc();
    chk("R2", "entered frozen", 32'(modeOut), 1);
    chk("R2", "halt forced", 32'(haltOut), 1);
    chk("R2", "freezeEn forced", 32'(frzEnOut), 1);
    chk("R2", "ack raised", 32'(frzAckOut), 1);
    // R3 clock source ignored while frozen
    wrMode(4'b0110);
    chk("R3", "clkSrc kept while frozen", 32'(clkSrcOut), 1);
    // R5 config accepted while frozen
    idle(); cfgWr = 1; cfgWdata = 16'hA5C3; cyc(); idle();
    chk("R5", "cfg write frozen", 32'(cfgOut), 32'h0000A5C3);
    // R6 clear halt -> synchronizing
    wrMode(4'b0100);
    cyc();
    chk("R6", "entered sync", 32'(modeOut), 2);
    // R7 dominant tick clears count
    ticks(10, 1'b1);
    ticks(1, 1'b0);
    chk("R7", "dominant tick restarts", 32'(modeOut), 2);
    ticks(5, 1'b1);
    rxIn = 0; repeat (3) cyc();
    ticks(5, 1'b1);
    chk("R7", "ten recessive not enough", 32'(modeOut), 2);
    idle(); cfgWr = 1; cfgWdata = 16'h1234; cyc(); idle();
    chk("R5", "cfg write sync", 32'(cfgOut), 32'h00001234);
    ticks(1, 1'b1);
    chk("R7", "eleventh recessive runs", 32'(modeOut), 3);
    chk("R8", "ack cleared", 32'(frzAckOut), 0);
    chk("R8", "notReady cleared", 32'(notRdyOut), 0);
    txEngine = 0; #1;
    chk("R8", "tx follows engine", 32'(txOut), 0);
    txEngine = 1;
    idle(); cfgWr = 1; cfgWdata = 16'hFFFF; cyc(); idle();
    chk("R5", "cfg write running dropped", 32'(cfgOut), 32'h00001234);
    // R9 halt without freeze-enable ignored
    wrMode(4'b0010);
    ticks(3, 1'b1);
    chk("R9", "halt ignored", 32'(modeOut), 3);
    wrMode(4'b0110);
    repeat (3) cyc();
    chk("R9", "waits for tick", 32'(modeOut), 3);
    ticks(1, 1'b1);
    chk("R9", "back to frozen", 32'(modeOut), 1);
    chk("R9", "ack reasserted", 32'(frzAckOut), 1);
    // R10 disable
    wrMode(4'b0111);
    cyc();
    chk("R10", "off mode", 32'(modeOut), 0);
    chk("R10", "off notReady", 32'(notRdyOut), 1);
    chk("R10", "off tx", 32'(txOut), 1);

    // seeded random phase, checked by the model each cycle
    for (int i = 0; i < RAND_CYC; i++) begin
      modeWr = ($urandom % 16) == 0;
      modeWdata = {1'($urandom % 2), 1'(($urandom % 4) != 0), 1'($urandom % 2), 1'(($urandom % 8) == 0)};
      cfgWr = ($urandom % 4) == 0;
      cfgWdata = CFG_W'($urandom);
      bitTick = ($urandom % 3) == 0;
      rxIn = ($urandom % 16) != 0;
      txEngine = 1'($urandom % 2);
      cyc();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule